// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block holds a handful of completed page translations in front of a hardware page walker. Each lookup presents a 36-bit virtual page number and an access kind: user or supervisor, read or write, data or instruction fetch. One cycle later the block reports a hit or a miss. A hit returns the 40-bit physical frame number and a protection-fault flag, which is worked out from the permission bits kept in the entry. A miss raises a walk request that carries the page number. Only final leaf translations are stored. The walker later installs its result through the fill port.

The buffer has eight entries, and any page can go in any entry. Software keeps it coherent in two ways. It can drop a single page by virtual page number, or it can flush every entry, which happens on a write to the root table base register. A fill for a page that is already present rewrites that entry, so a tag is never held twice. A new page takes the lowest-numbered free entry. When no entry is free, a round-robin pointer picks the victim.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` and `walk_req` are 0, and the first lookup of any page misses.
- R2: A lookup of an installed page asserts `rsp_valid` and `rsp_hit` on the cycle after `lk_valid`, returns the stored frame on `rsp_pfn`, and leaves `walk_req` low.
- R3: A lookup that misses gives `rsp_hit`=0 and `rsp_fault`=0 one cycle later, together with `walk_req`=1 and `walk_vpn` equal to the page that was looked up.
- R4: A permission code is {user_ok, writable, no_exec} in bits [2:0], and an access code is {from_user, is_write, is_fetch}. A hit faults when any of these holds: a user access to a page with user_ok=0, a write to a page with writable=0, or a fetch from a page with no_exec=1. A faulting hit still returns the frame.
- R5: `inv_valid` removes the entry whose tag equals `inv_vpn`. Later lookups of that page miss, and other pages keep hitting.
- R6: `root_wr` empties the buffer and sends the replacement pointer back to entry 0. A fill in the same cycle is dropped.
- R7: A fill for a new page goes to the lowest-numbered invalid entry, and no valid entry is evicted while an invalid one exists.
- R8: When all entries are valid, a fill for a new page replaces the entry under the round-robin pointer. The pointer starts at entry 0 and steps by one on each such replacement.
- R9: A fill whose tag is already present rewrites that entry in place, does not move the pointer, and never creates a second copy of the tag.
- R10: An invalidate and a fill for the same page in the same cycle leave that page absent.
- R11: A lookup sees the contents as they were before any fill made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | 36 | Virtual page number to translate |
| lk_acc | input | 3 | Access code {from_user, is_write, is_fetch} |
| fill_valid | input | 1 | Install strobe from the walker |
| fill_vpn | input | 36 | Tag to install |
| fill_pfn | input | 40 | Frame to install |
| fill_perm | input | 3 | Permission code {user_ok, writable, no_exec} |
| inv_valid | input | 1 | Single-page invalidate strobe |
| inv_vpn | input | 36 | Page to invalidate |
| root_wr | input | 1 | Root table base write; flushes all entries |
| rsp_valid | output | 1 | Registered lookup result is present |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_pfn | output | 40 | Translated frame number (0 on a miss) |
| rsp_fault | output | 1 | Hit violates the stored permissions |
| walk_req | output | 1 | Miss; walk needed |
| walk_vpn | output | 36 | Page the walk must resolve |

## Verification
Both a fill and an invalidate can reach the table in one cycle, and so can a fill and a root-table write. A lookup can also arrive in the same cycle as a fill of the page it asks for. The bench drives each pair on a single clock edge and then looks up the page on its own. The invalidate and the flush must each win, leaving a miss. The lookup that shared a cycle with a fill must see the old contents and miss, and the next lookup must hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W = 36;
    localparam int PFN_W = 40;
    localparam int ENTRIES = 8;

    typedef struct packed {
        logic user_ok;
        logic writable;
        logic no_exec;
    } perm_t;

    typedef struct packed {
        logic from_user;
        logic is_write;
        logic is_fetch;
    } access_t;

    function automatic logic perm_violation(perm_t p, access_t a);
        return (a.from_user & ~p.user_ok) |
               (a.is_write  & ~p.writable) |
               (a.is_fetch  &  p.no_exec);
    endfunction
endpackage

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
    import tlb_pkg::*;
(
    input  perm_t   perm,
    input  access_t acc,
    input  logic    hit,
    output logic    fault
);
    always_comb fault = hit & perm_violation(perm, acc);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [N-1:0]  valid_vec,
    input  logic          advance,
    output logic [IW-1:0] victim_idx
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] ptr;
    logic          all_valid;

    always_comb begin
        all_valid  = &valid_vec;
        victim_idx = ptr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) ptr <= '0;
        else if (advance && all_valid) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R7: a free entry is always preferred over eviction
    a_r7_free_first: assert property (@(posedge clk) disable iff (rst)
        !(&valid_vec) |-> !valid_vec[victim_idx]);

    // R8: the pointer steps by one per replacement
    a_r8_rr_step: assert property (@(posedge clk) disable iff (rst)
        (advance && (&valid_vec) && !flush && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N  = 8,
    parameter int VW = 36,
    parameter int PW = 40,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          inv_valid,
    input  logic [VW-1:0] inv_vpn,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [VW-1:0] wr_vpn,
    input  logic [PW-1:0] wr_pfn,
    input  perm_t         wr_perm,
    input  logic [VW-1:0] lk_vpn,
    output logic          lk_hit,
    output logic [PW-1:0] lk_pfn,
    output perm_t         lk_perm,
    input  logic [VW-1:0] fill_vpn,
    output logic          fill_hit,
    output logic [IW-1:0] fill_idx,
    output logic [N-1:0]  valid_vec
);
    logic [VW-1:0] tag  [N];
    logic [PW-1:0] pfn  [N];
    perm_t         perm [N];
    logic [N-1:0]  vld;

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                vld[i]  <= 1'b0;
                tag[i]  <= '0;
                pfn[i]  <= '0;
                perm[i] <= '0;
            end else begin
                if (inv_valid && tag[i] == inv_vpn) vld[i] <= 1'b0;
                if (wr_en && wr_idx == IW'(i)) begin
                    vld[i]  <= 1'b1;
                    tag[i]  <= wr_vpn;
                    pfn[i]  <= wr_pfn;
                    perm[i] <= wr_perm;
                end
            end
        end

        // R5: a matching entry is gone after an invalidate
        a_r5_inv_clears: assert property (@(posedge clk) disable iff (rst)
            (inv_valid && vld[i] && tag[i] == inv_vpn && !(wr_en && wr_idx == IW'(i)))
            |=> !vld[i]);
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_pfn   = '0;
        lk_perm  = '0;
        fill_hit = 1'b0;
        fill_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && tag[i] == lk_vpn) begin
                lk_hit  = 1'b1;
                lk_pfn  = lk_pfn | pfn[i];
                lk_perm = lk_perm | perm[i];
            end
            if (vld[i] && tag[i] == fill_vpn) begin
                fill_hit = 1'b1;
                fill_idx = fill_idx | IW'(i);
            end
        end
    end

    assign valid_vec = vld;

    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
                if (vld[i] && vld[j] && tag[i] == tag[j]) dup = 1'b1;
    end

    // R9: no tag is held twice
    a_r9_no_dup: assert property (@(posedge clk) disable iff (rst) !dup);

    // R6: a flush leaves the table empty
    a_r6_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> vld == '0);
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int N  = ENTRIES,
    parameter int VW = VPN_W,
    parameter int PW = PFN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lk_valid,
    input  logic [VW-1:0] lk_vpn,
    input  logic [2:0]    lk_acc,
    input  logic          fill_valid,
    input  logic [VW-1:0] fill_vpn,
    input  logic [PW-1:0] fill_pfn,
    input  logic [2:0]    fill_perm,
    input  logic          inv_valid,
    input  logic [VW-1:0] inv_vpn,
    input  logic          root_wr,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic [PW-1:0] rsp_pfn,
    output logic          rsp_fault,
    output logic          walk_req,
    output logic [VW-1:0] walk_vpn
);
    localparam int IW = $clog2(N);

    logic          lk_hit, fill_hit, fill_ok, wr_en, lk_fault;
    logic [PW-1:0] lk_pfn;
    perm_t         lk_perm;
    logic [IW-1:0] fill_idx, victim_idx, wr_idx;
    logic [N-1:0]  valid_vec;

    always_comb begin
        fill_ok = fill_valid && !root_wr && !(inv_valid && inv_vpn == fill_vpn);
        wr_en   = fill_ok;
        wr_idx  = fill_hit ? fill_idx : victim_idx;
    end

    tlb_cam #(.N(N), .VW(VW), .PW(PW), .IW(IW)) i_cam (
        .clk(clk), .rst(rst), .flush(root_wr),
        .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(fill_vpn),
        .wr_pfn(fill_pfn), .wr_perm(perm_t'(fill_perm)),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
        .fill_vpn(fill_vpn), .fill_hit(fill_hit), .fill_idx(fill_idx),
        .valid_vec(valid_vec)
    );

    tlb_victim #(.N(N), .IW(IW)) i_victim (
        .clk(clk), .rst(rst), .flush(root_wr), .valid_vec(valid_vec),
        .advance(fill_ok && !fill_hit), .victim_idx(victim_idx)
    );

    tlb_perm_chk i_perm (
        .perm(lk_perm), .acc(access_t'(lk_acc)), .hit(lk_hit), .fault(lk_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pfn   <= '0;
            rsp_fault <= 1'b0;
            walk_req  <= 1'b0;
            walk_vpn  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_pfn   <= (lk_valid && lk_hit) ? lk_pfn : '0;
            rsp_fault <= lk_valid && lk_fault;
            walk_req  <= lk_valid && !lk_hit;
            walk_vpn  <= lk_vpn;
        end
    end

    // R4: only a hit can fault
    a_r4_fault_on_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_hit);

    // R3: the walk carries the page that missed
    a_r3_walk_page: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |=> (walk_req && walk_vpn == $past(lk_vpn)));
endmodule

// File: tb/test_tlb_top.sv
`timescale 1ns/1ps
module test_tlb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid = 0, fill_valid = 0, inv_valid = 0, root_wr = 0;
    logic [35:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
    logic [2:0]  lk_acc = '0, fill_perm = '0;
    logic [39:0] fill_pfn = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, walk_req;
    logic [39:0] rsp_pfn;
    logic [35:0] walk_vpn;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    tlb_top i_tlb_top (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_perm(fill_perm), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .root_wr(root_wr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_pfn(rsp_pfn), .rsp_fault(rsp_fault), .walk_req(walk_req),
        .walk_vpn(walk_vpn)
    );

    // vector table: page, frame, permission, access, expected fault
    localparam logic [35:0] T_VPN  [8] = '{36'h0_0000_0010, 36'h0_0000_0011,
        36'h1_2345_6000, 36'h7_FFFF_FFFF, 36'hA_BCDE_F012, 36'h0_0000_0000,
        36'h5_5555_5555, 36'hF_0000_0001};
    localparam logic [39:0] T_PFN  [8] = '{40'h00_0000_1000, 40'h12_3456_789A,
        40'hFF_FFFF_FFFF, 40'h00_0000_0001, 40'h80_0000_0000, 40'h0A_0A0A_0A0A,
        40'h33_4455_6677, 40'h01_0203_0405};
    localparam logic [2:0] T_PERM [8] = '{3'b110, 3'b010, 3'b100, 3'b111,
        3'b110, 3'b110, 3'b000, 3'b101};
    localparam logic [2:0] T_ACC  [8] = '{3'b000, 3'b100, 3'b110, 3'b101,
        3'b111, 3'b001, 3'b000, 3'b010};
    localparam logic       T_FLT  [8] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [35:0] v, input logic [39:0] p, input logic [2:0] pm);
        @(negedge clk);
        fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_perm = pm;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic inval(input logic [35:0] v);
        @(negedge clk);
        inv_valid = 1; inv_vpn = v;
        @(negedge clk);
        inv_valid = 0;
    endtask

    task automatic lookup(input logic [35:0] v, input logic [2:0] a);
        @(negedge clk);
        lk_valid = 1; lk_vpn = v; lk_acc = a;
        @(negedge clk);
        lk_valid = 0;
    endtask

    task automatic expect_hit(input logic [35:0] v, input logic [39:0] p, input string req);
        lookup(v, 3'b000);
        chk(rsp_valid && rsp_hit && !walk_req, req, {rsp_valid, rsp_hit, walk_req}, 3'b110);
        chk(rsp_pfn == p, req, rsp_pfn, p);
    endtask

    task automatic expect_miss(input logic [35:0] v, input string req);
        lookup(v, 3'b100);
        chk(rsp_valid && !rsp_hit && walk_req && !rsp_fault && walk_vpn == v, req,
            {rsp_hit, walk_req, walk_vpn}, {2'b01, v});
    endtask

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(!rsp_valid && !walk_req, "R1 reset outputs", {rsp_valid, walk_req}, 0);
        expect_miss(T_VPN[0], "R1 empty after reset");

        // R2 / R4: table walk of installs and permission checks
        for (int i = 0; i < 8; i++) fill(T_VPN[i], T_PFN[i], T_PERM[i]);
        for (int i = 0; i < 8; i++) begin
            lookup(T_VPN[i], T_ACC[i]);
            chk(rsp_valid && rsp_hit && !walk_req, "R2 hit", {rsp_valid, rsp_hit, walk_req}, 3'b110);
            chk(rsp_pfn == T_PFN[i], "R2 frame", rsp_pfn, T_PFN[i]);
            chk(rsp_fault == T_FLT[i], "R4 fault", rsp_fault, T_FLT[i]);
        end

        // R3: miss requests a walk and never faults
        expect_miss(36'h9_9999_9999, "R3 miss");

        // R9: refill updates in place
        fill(T_VPN[3], 40'hDE_AD00_BEEF, 3'b111);
        expect_hit(T_VPN[3], 40'hDE_AD00_BEEF, "R9 rewrite");
        for (int i = 0; i < 8; i++) expect_hit(T_VPN[i], (i == 3) ? 40'hDE_AD00_BEEF : T_PFN[i], "R9 nothing evicted");

        // R5: single page invalidate
        inval(T_VPN[5]);
        expect_miss(T_VPN[5], "R5 page removed");
        expect_hit(T_VPN[4], T_PFN[4], "R5 neighbour kept");

        // R7: free slot reused before eviction
        fill(36'h2_2222_2222, 40'h22_2222_2222, 3'b110);
        for (int i = 0; i < 8; i++)
            if (i != 5) expect_hit(T_VPN[i], (i == 3) ? 40'hDE_AD00_BEEF : T_PFN[i], "R7 no eviction");
        expect_hit(36'h2_2222_2222, 40'h22_2222_2222, "R7 new page");

        // R8: round-robin replacement from entry 0
        fill(36'h3_0000_0000, 40'h30_0000_0000, 3'b110);
        fill(36'h3_0000_0001, 40'h30_0000_0001, 3'b110);
        expect_miss(T_VPN[0], "R8 entry0 replaced");
        expect_miss(T_VPN[1], "R8 entry1 replaced");
        expect_hit(T_VPN[2], T_PFN[2], "R8 entry2 kept");
        expect_hit(36'h3_0000_0000, 40'h30_0000_0000, "R8 first new");
        expect_hit(36'h3_0000_0001, 40'h30_0000_0001, "R8 second new");

        // R10: invalidate beats fill of the same page
        @(negedge clk);
        fill_valid = 1; fill_vpn = 36'h4_4444_4444; fill_pfn = 40'h44; fill_perm = 3'b110;
        inv_valid = 1; inv_vpn = 36'h4_4444_4444;
        @(negedge clk);
        fill_valid = 0; inv_valid = 0;
        expect_miss(36'h4_4444_4444, "R10 fill dropped");
        expect_hit(T_VPN[2], T_PFN[2], "R10 no replacement");

        // R11: lookup alongside a fill of the same page sees old state
        @(negedge clk);
        fill_valid = 1; fill_vpn = 36'h6_6666_6666; fill_pfn = 40'h66; fill_perm = 3'b110;
        lk_valid = 1; lk_vpn = 36'h6_6666_6666; lk_acc = 3'b000;
        @(negedge clk);
        fill_valid = 0; lk_valid = 0;
        chk(rsp_valid && !rsp_hit && walk_req, "R11 same-cycle miss", {rsp_hit, walk_req}, 2'b01);
        expect_hit(36'h6_6666_6666, 40'h66, "R11 later hit");

        // R6: flush, flush versus fill, pointer back to entry 0
        @(negedge clk);
        root_wr = 1;
        fill_valid = 1; fill_vpn = 36'h7_7777_7777; fill_pfn = 40'h77; fill_perm = 3'b110;
        @(negedge clk);
        root_wr = 0; fill_valid = 0;
        expect_miss(36'h3_0000_0000, "R6 flushed");
        expect_miss(T_VPN[4], "R6 flushed");
        expect_miss(36'h7_7777_7777, "R6 fill dropped");
        for (int i = 0; i < 8; i++) fill(36'h8_0000_0000 + 36'(i), 40'h800 + 40'(i), 3'b110);
        fill(36'h8_0000_00FF, 40'h8FF, 3'b110);
        expect_miss(36'h8_0000_0000, "R6 pointer reset");
        expect_hit(36'h8_0000_0001, 40'h801, "R6 pointer reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule